// File: doc/BRIEF.md
# PCI Express Function Status Register

This block holds the 16-bit status half of the command/status dword in a PCI Express endpoint's configuration header. The link and transaction layers send single-cycle event pulses: a poisoned packet arrived, an error message went out, a completion came back with an abort code, and so on. The block turns each pulse into a sticky flag. Two of the flags are also qualified by enable levels taken from the command register. Software reads the flags and clears each one by writing 1 to its bit position.

The remaining fields are fixed. The capabilities-list bit always reads 1, and the legacy bus fields always read 0. Bit 3 is a live copy of the function's interrupt-pending level. The configuration port addresses whole dwords. The status occupies bytes 2 and 3 of dword index 1 (byte offset 04h), with the status bit n at data bit n+16. Read data comes back combinationally from the address.

Top module: `cfg_status_reg`

## Requirements
- R1: After reset, with no events and the interrupt level low, a read of dword 1 returns 0x0010 in bits 31:16.
- R2: A pulse on `ev_poison_rx` sets status bit 15 whether `cmd_perr_en` is 0 or 1.
- R3: A pulse on `ev_errmsg_tx` sets status bit 14 only while `cmd_serr_en` is 1. With the enable at 0, bit 14 is not set.
- R4: A pulse on `ev_cpl_ur_rx` sets status bit 13. A pulse on `ev_cpl_ca_rx` sets status bit 12.
- R5: A pulse on `ev_cpl_ca_tx` sets status bit 11.
- R6: Status bit 8 is set by a pulse on `ev_poison_cpl_rx` or on `ev_poison_wr_tx`, but only while `cmd_perr_en` is 1.
- R7: Bits 10:9, 7, 6, 5 and 2:0 always read 0, and bit 4 always reads 1. Writes to any of these bits have no effect.
- R8: Bit 3 follows `intr_pending` combinationally and holds no state of its own.
- R9: Bits 15:11 and 8 hold their value once set. A write of 1 to one of these bits clears it, and a write of 0 leaves it unchanged.
- R10: A clear takes effect only when `cfg_wr` is 1, `cfg_addr` equals 1 and `cfg_be[3]` is 1. `cfg_be[2]` alone clears nothing.
- R11: When a set pulse and a clearing write hit the same flag in the same cycle, the flag ends the cycle at 1.
- R12: `cfg_rdata[15:0]` always reads 0. A read of any address other than 1 returns 0 on all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | ADDR_W | Configuration dword index |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_be | input | 4 | Byte enables for the dword |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data |
| cmd_perr_en | input | 1 | Parity-error response enable from the command register |
| cmd_serr_en | input | 1 | System-error enable from the command register |
| intr_pending | input | 1 | Live interrupt-pending level |
| ev_poison_rx | input | 1 | Poisoned packet received |
| ev_errmsg_tx | input | 1 | Fatal or non-fatal error message sent |
| ev_cpl_ur_rx | input | 1 | Completion with Unsupported Request status received |
| ev_cpl_ca_rx | input | 1 | Completion with Completer Abort status received |
| ev_cpl_ca_tx | input | 1 | Function completed a request with Completer Abort status |
| ev_poison_cpl_rx | input | 1 | Poisoned completion with data received |
| ev_poison_wr_tx | input | 1 | Function poisoned a received write request |

## Verification
The assertions check the flag protocol on every cycle:
- a flag with neither a set nor a clear keeps its value;
- a set always leaves the flag at 1, including when a clear arrives in the same cycle;
- a clear with no set drops the flag;
- the enable-gated flags stay low while their enable is off.

Only the bench's scenarios can show the rest:
- the mapping from each event input to its bit position;
- the fixed pattern of the constant fields;
- that the interrupt bit follows its input without a clock;
- that writes with the wrong byte lane or the wrong address clear nothing.

// File: rtl/cfg_status_pkg.sv
package cfg_status_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned BE_W      = DATA_W / 8;
  localparam int unsigned STAT_W    = 16;
  localparam int unsigned NUM_FLAGS = 6;

  // Sticky flag slots, in the order of the flag vector
  localparam int unsigned F_DATAPAR = 0;  // status bit 8
  localparam int unsigned F_CA_SENT = 1;  // status bit 11
  localparam int unsigned F_CA_RCVD = 2;  // status bit 12
  localparam int unsigned F_UR_RCVD = 3;  // status bit 13
  localparam int unsigned F_SYS_ERR = 4;  // status bit 14
  localparam int unsigned F_PAR_DET = 5;  // status bit 15

  // Status bit position of each flag slot (software decodes these)
  function automatic int unsigned flag_pos(input int unsigned slot);
    return (slot == F_DATAPAR) ? 8 : (slot + 10);
  endfunction
endpackage

// File: rtl/stat_event_map.sv
module stat_event_map
  import cfg_status_pkg::*;
(
  input  logic                 cmd_perr_en,
  input  logic                 cmd_serr_en,
  input  logic                 ev_poison_rx,
  input  logic                 ev_errmsg_tx,
  input  logic                 ev_cpl_ur_rx,
  input  logic                 ev_cpl_ca_rx,
  input  logic                 ev_cpl_ca_tx,
  input  logic                 ev_poison_cpl_rx,
  input  logic                 ev_poison_wr_tx,
  output logic [NUM_FLAGS-1:0] flag_set
);
  always_comb begin
    flag_set            = '0;
    flag_set[F_PAR_DET] = ev_poison_rx;
    flag_set[F_SYS_ERR] = ev_errmsg_tx & cmd_serr_en;
    flag_set[F_UR_RCVD] = ev_cpl_ur_rx;
    flag_set[F_CA_RCVD] = ev_cpl_ca_rx;
    flag_set[F_CA_SENT] = ev_cpl_ca_tx;
    flag_set[F_DATAPAR] = cmd_perr_en & (ev_poison_cpl_rx | ev_poison_wr_tx);
  end
endmodule

// File: rtl/stat_sticky_flag.sv
module stat_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> (flag_o == $past(flag_o)));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R9
  w1c_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/stat_cfg_decode.sv
module stat_cfg_decode
  import cfg_status_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned STAT_DWORD = 1
) (
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic                 cfg_wr,
  input  logic [BE_W-1:0]      cfg_be,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic                 addr_hit,
  output logic [NUM_FLAGS-1:0] flag_clr
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STAT_DWORD);
  localparam int unsigned       STAT_LSB = DATA_W - STAT_W;
  localparam int unsigned       HI_LANE  = (STAT_LSB + 8) / 8;

  logic hi_wr;

  assign addr_hit = (cfg_addr == HIT_ADDR);
  assign hi_wr    = cfg_wr & addr_hit & cfg_be[HI_LANE];

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_clr
    assign flag_clr[g] = hi_wr & cfg_wdata[STAT_LSB + flag_pos(g)];
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^{cfg_be[HI_LANE-1:0], cfg_wdata[STAT_LSB+10:STAT_LSB+9],
                            cfg_wdata[STAT_LSB+7:0]};
endmodule

// File: rtl/cfg_status_reg.sv
module cfg_status_reg
  import cfg_status_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned STAT_DWORD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              cmd_perr_en,
  input  logic              cmd_serr_en,
  input  logic              intr_pending,
  input  logic              ev_poison_rx,
  input  logic              ev_errmsg_tx,
  input  logic              ev_cpl_ur_rx,
  input  logic              ev_cpl_ca_rx,
  input  logic              ev_cpl_ca_tx,
  input  logic              ev_poison_cpl_rx,
  input  logic              ev_poison_wr_tx
);
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 addr_hit;
  logic [STAT_W-1:0]    status;

  stat_event_map u_map (
    .cmd_perr_en      (cmd_perr_en),
    .cmd_serr_en      (cmd_serr_en),
    .ev_poison_rx     (ev_poison_rx),
    .ev_errmsg_tx     (ev_errmsg_tx),
    .ev_cpl_ur_rx     (ev_cpl_ur_rx),
    .ev_cpl_ca_rx     (ev_cpl_ca_rx),
    .ev_cpl_ca_tx     (ev_cpl_ca_tx),
    .ev_poison_cpl_rx (ev_poison_cpl_rx),
    .ev_poison_wr_tx  (ev_poison_wr_tx),
    .flag_set         (flag_set)
  );

  stat_cfg_decode #(
    .ADDR_W     (ADDR_W),
    .STAT_DWORD (STAT_DWORD)
  ) u_dec (
    .cfg_addr  (cfg_addr),
    .cfg_wr    (cfg_wr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .addr_hit  (addr_hit),
    .flag_clr  (flag_clr)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    stat_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .flag_o (flag_q[g])
    );
  end

  always_comb begin
    status    = '0;
    status[4] = 1'b1;
    status[3] = intr_pending;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      status[flag_pos(i)] = flag_q[i];
    end
    cfg_rdata = addr_hit ? {status, {(DATA_W-STAT_W){1'b0}}} : '0;
  end

  // R3
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_serr_en && !flag_q[F_SYS_ERR]) |=> !flag_q[F_SYS_ERR]);

  // R6
  perr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_perr_en && !flag_q[F_DATAPAR]) |=> !flag_q[F_DATAPAR]);

  // R2
  poison_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_poison_rx |=> flag_q[F_PAR_DET]);

  // R12
  low_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[15:0] == 16'h0);
endmodule

// File: tb/cfg_status_reg_test.sv
`timescale 1ns/1ps
module cfg_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cmd_perr_en = 1'b0, cmd_serr_en = 1'b0, intr_pending = 1'b0;
  logic        ev_poison_rx = 1'b0, ev_errmsg_tx = 1'b0, ev_cpl_ur_rx = 1'b0;
  logic        ev_cpl_ca_rx = 1'b0, ev_cpl_ca_tx = 1'b0;
  logic        ev_poison_cpl_rx = 1'b0, ev_poison_wr_tx = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_status_reg uut (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [15:0] exp, input string req);
    cfg_addr = a;
    #1;
    check(cfg_rdata, {exp, 16'h0}, req);
  endtask

  task automatic wr(input logic [9:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0; cfg_addr = 10'd1;
  endtask

  task automatic clear_all();
    wr(10'd1, 4'b1000, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    rd_chk(10'd1, 16'h0010, "R1");
    cfg_addr = 10'd0; #1; check(cfg_rdata, 32'h0, "R12 addr 0");
    cfg_addr = 10'd2; #1; check(cfg_rdata, 32'h0, "R12 addr 2");
    cfg_addr = 10'd1;
  endtask

  task automatic t_poison();
    cmd_perr_en = 1'b0;
    @(negedge clk); ev_poison_rx = 1'b1; @(negedge clk); ev_poison_rx = 1'b0;
    rd_chk(10'd1, 16'h8010, "R2 perr off");
    clear_all();
    cmd_perr_en = 1'b1;
    @(negedge clk); ev_poison_rx = 1'b1; @(negedge clk); ev_poison_rx = 1'b0;
    rd_chk(10'd1, 16'h8010, "R2 perr on");
    clear_all();
    cmd_perr_en = 1'b0;
    rd_chk(10'd1, 16'h0010, "R9 clear bit15");
  endtask

  task automatic t_serr();
    cmd_serr_en = 1'b0;
    @(negedge clk); ev_errmsg_tx = 1'b1; @(negedge clk); ev_errmsg_tx = 1'b0;
    rd_chk(10'd1, 16'h0010, "R3 serr off");
    cmd_serr_en = 1'b1;
    @(negedge clk); ev_errmsg_tx = 1'b1; @(negedge clk); ev_errmsg_tx = 1'b0;
    rd_chk(10'd1, 16'h4010, "R3 serr on");
    cmd_serr_en = 1'b0;
    rd_chk(10'd1, 16'h4010, "R9 bit14 kept after enable drop");
    clear_all();
  endtask

  task automatic t_aborts();
    @(negedge clk); ev_cpl_ur_rx = 1'b1; @(negedge clk); ev_cpl_ur_rx = 1'b0;
    rd_chk(10'd1, 16'h2010, "R4 UR");
    @(negedge clk); ev_cpl_ca_rx = 1'b1; @(negedge clk); ev_cpl_ca_rx = 1'b0;
    rd_chk(10'd1, 16'h3010, "R4 CA rx");
    @(negedge clk); ev_cpl_ca_tx = 1'b1; @(negedge clk); ev_cpl_ca_tx = 1'b0;
    rd_chk(10'd1, 16'h3810, "R5 CA tx");
    clear_all();
  endtask

  task automatic t_datapar();
    cmd_perr_en = 1'b0;
    @(negedge clk); ev_poison_cpl_rx = 1'b1; ev_poison_wr_tx = 1'b1;
    @(negedge clk); ev_poison_cpl_rx = 1'b0; ev_poison_wr_tx = 1'b0;
    rd_chk(10'd1, 16'h0010, "R6 perr off");
    cmd_perr_en = 1'b1;
    @(negedge clk); ev_poison_cpl_rx = 1'b1; @(negedge clk); ev_poison_cpl_rx = 1'b0;
    rd_chk(10'd1, 16'h0110, "R6 poisoned cpl");
    clear_all();
    @(negedge clk); ev_poison_wr_tx = 1'b1; @(negedge clk); ev_poison_wr_tx = 1'b0;
    rd_chk(10'd1, 16'h0110, "R6 poisoned write");
    clear_all();
    cmd_perr_en = 1'b0;
  endtask

  task automatic t_w1c();
    cmd_perr_en = 1'b1; cmd_serr_en = 1'b1;
    @(negedge clk);
    ev_poison_rx = 1'b1; ev_errmsg_tx = 1'b1; ev_cpl_ur_rx = 1'b1;
    ev_cpl_ca_rx = 1'b1; ev_cpl_ca_tx = 1'b1; ev_poison_cpl_rx = 1'b1;
    @(negedge clk);
    ev_poison_rx = 1'b0; ev_errmsg_tx = 1'b0; ev_cpl_ur_rx = 1'b0;
    ev_cpl_ca_rx = 1'b0; ev_cpl_ca_tx = 1'b0; ev_poison_cpl_rx = 1'b0;
    cmd_perr_en = 1'b0; cmd_serr_en = 1'b0;
    rd_chk(10'd1, 16'hF910, "R9 all set");
    wr(10'd1, 4'b1000, 32'h0000_0000);
    rd_chk(10'd1, 16'hF910, "R9 write zero keeps");
    wr(10'd1, 4'b0111, 32'hFFFF_FFFF);
    rd_chk(10'd1, 16'hF910, "R10 no upper lane");
    wr(10'd0, 4'b1111, 32'hFFFF_FFFF);
    rd_chk(10'd1, 16'hF910, "R10 wrong address");
    wr(10'd1, 4'b1000, 32'h4100_0000);
    rd_chk(10'd1, 16'hB810, "R9 partial clear");
    clear_all();
    rd_chk(10'd1, 16'h0010, "R9 full clear");
  endtask

  task automatic t_const();
    wr(10'd1, 4'b1111, 32'h06FF_FFFF);
    rd_chk(10'd1, 16'h0010, "R7 constants");
  endtask

  task automatic t_intr();
    cfg_addr = 10'd1;
    intr_pending = 1'b1; #1;
    check(cfg_rdata, 32'h0018_0000, "R8 level high");
    wr(10'd1, 4'b1100, 32'h0008_0000);
    intr_pending = 1'b1; #1;
    check(cfg_rdata, 32'h0018_0000, "R8 write ignored");
    intr_pending = 1'b0; #1;
    check(cfg_rdata, 32'h0010_0000, "R8 level low");
  endtask

  task automatic t_collide();
    @(negedge clk); ev_cpl_ur_rx = 1'b1; @(negedge clk); ev_cpl_ur_rx = 1'b0;
    @(negedge clk);
    cfg_addr = 10'd1; cfg_be = 4'b1000; cfg_wdata = 32'hFFFF_FFFF; cfg_wr = 1'b1;
    ev_poison_rx = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0; ev_poison_rx = 1'b0;
    rd_chk(10'd1, 16'h8010, "R11 set beats clear");
    clear_all();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_addr = 10'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_poison();
    t_serr();
    t_aborts();
    t_datapar();
    t_w1c();
    t_const();
    t_intr();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule